// File: doc/BRIEF.md
# Per-Bank Open-Row Tracker

This block sits beside a memory controller and listens to the command pins it drives toward a four-bank DDR SDRAM. It keeps a small record for each bank: whether a row is open, and which row. It decodes row activation, column read, precharge, no-operation and deselect from the chip-select, row-strobe, column-strobe and write-enable pins, together with the bank bits and the address bus.

The scheduler asks a combinational query port about a bank and row it wants to reach next. The answer is hit (that row is already open), idle (the bank needs an activation first) or conflict (a different row must be closed first). The tracker also reports a protocol error one cycle after it sees an activation to a bank that is already open, or a read to a bank that is idle.

A read with address bit 10 high schedules an automatic close. The bank goes idle once the burst has finished, which is half the burst length in clock cycles after the read.

Top module: `bank_row_tracker`

## Requirements
- R1: After reset every bank is idle, `bank_open` is all zero and `cmd_err` is low.
- R2: An activation (`cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=1) to an idle bank opens the row on `addr` in bank `ba`. From the next cycle `bank_open[ba]` is 1 and a query of that row answers hit.
- R3: An activation to a bank that already holds an open row raises `cmd_err` for exactly the one cycle after it, and leaves the stored row unchanged.
- R4: A read (`cs_n`=0, `ras_n`=1, `cas_n`=0, `we_n`=1) to an idle bank raises `cmd_err` for one cycle. A read with `addr[10]`=0 to an open bank changes nothing.
- R5: A read with `addr[10]`=1 to an open bank closes that bank exactly BURST_LEN/2 clock edges after the read edge. The close still happens when another command arrives on that edge.
- R6: A precharge (`cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0) closes bank `ba` when `addr[10]`=0, and closes all banks when `addr[10]`=1. It cancels any pending automatic close on the banks it closes.
- R7: With `cs_n`=1 the other pins are ignored, while a pending automatic close still completes.
- R8: A no-operation (`cs_n`=0 with the three strobes high) changes no bank state and raises no error.
- R9: `qry_status` answers, in the same cycle, 0 when bank `qry_bank` is idle, 1 when it holds `qry_row`, and 2 when it holds another row.
- R10: Any other strobe pattern with `cs_n`=0, such as a write or a refresh, leaves bank state unchanged and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are taken on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row address; bit 10 selects auto-close or all-bank close |
| qry_bank | input | 2 | Bank being asked about |
| qry_row | input | 13 | Row being asked about |
| qry_status | output | 2 | 0 idle, 1 hit, 2 conflict |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| cmd_err | output | 1 | One-cycle pulse after an illegal activation or read |

## Verification
The automatic close of one bank and a freshly registered command can land on the same clock edge. The bench provokes this by counting the edges after an auto-closing read and placing a command on the expiry edge. In one case it is an activation to a different bank; there the bench expects both banks to change together, with no error. In the other case it is an activation to the expiring bank itself; there the bench expects an error, because the bank is still open on that edge, and also expects the bank to end up idle rather than reopened.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_ACT,
        CMD_RD,
        CMD_PRE,
        CMD_MISC
    } cmd_e;

    typedef enum logic [1:0] {
        QRY_IDLE     = 2'd0,
        QRY_HIT      = 2'd1,
        QRY_CONFLICT = 2'd2
    } qry_e;

endpackage

// File: rtl/brt_cmd_decode.sv
module brt_cmd_decode
    import brt_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_IDLE;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_IDLE;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_MISC;
            endcase
        end
    end

endmodule

// File: rtl/brt_bank_slice.sv
module brt_bank_slice
    import brt_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int BURST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic             sel,
    input  logic             a10,
    input  logic [ROW_W-1:0] row_in,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             illegal_o
);

    localparam int CNT_MAX = BURST_LEN / 2;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] cnt;
    } slice_t;

    slice_t st_d, st_q;
    logic   illegal_d;

    always_comb begin
        st_d      = st_q;
        illegal_d = 1'b0;

        // pending auto-close countdown runs regardless of the new command
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.open = 1'b0;
            end
        end

        unique case (cmd)
            CMD_ACT: begin
                if (sel) begin
                    if (st_q.open) begin
                        illegal_d = 1'b1;
                    end else begin
                        st_d.open = 1'b1;
                        st_d.row  = row_in;
                        st_d.cnt  = '0;
                    end
                end
            end
            CMD_RD: begin
                if (sel) begin
                    if (!st_q.open) begin
                        illegal_d = 1'b1;
                    end else if (a10 && st_q.cnt == '0) begin
                        st_d.cnt = CNT_W'(CNT_MAX);
                    end
                end
            end
            CMD_PRE: begin
                if (sel || a10) begin
                    st_d.open = 1'b0;
                    st_d.cnt  = '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o    = st_q.open;
    assign row_o     = st_q.row;
    assign illegal_o = illegal_d;

endmodule

// File: rtl/brt_query.sv
module brt_query
    import brt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS-1:0]            open_vec,
    input  logic [NUM_BANKS-1:0][ROW_W-1:0] rows,
    input  logic [BA_W-1:0]                 qry_bank,
    input  logic [ROW_W-1:0]                qry_row,
    output qry_e                            status
);

    always_comb begin
        if (!open_vec[qry_bank]) begin
            status = QRY_IDLE;
        end else if (rows[qry_bank] == qry_row) begin
            status = QRY_HIT;
        end else begin
            status = QRY_CONFLICT;
        end
    end

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
    import brt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ROW_W-1:0]     addr,
    input  logic [BA_W-1:0]      qry_bank,
    input  logic [ROW_W-1:0]     qry_row,
    output logic [1:0]           qry_status,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 cmd_err
);

    typedef struct packed {
        logic err;
    } top_t;

    cmd_e                            cmd;
    logic [NUM_BANKS-1:0]            illegal_vec;
    logic [NUM_BANKS-1:0][ROW_W-1:0] row_vec;
    qry_e                            qst;
    top_t                            top_d, top_q;

    brt_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        brt_bank_slice #(
            .ROW_W     (ROW_W),
            .BURST_LEN (BURST_LEN)
        ) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd),
            .sel       (ba == BA_W'(g)),
            .a10       (addr[10]),
            .row_in    (addr),
            .open_o    (bank_open[g]),
            .row_o     (row_vec[g]),
            .illegal_o (illegal_vec[g])
        );
    end

    brt_query #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W)
    ) u_qry (
        .open_vec (bank_open),
        .rows     (row_vec),
        .qry_bank (qry_bank),
        .qry_row  (qry_row),
        .status   (qst)
    );

    always_comb begin
        top_d     = top_q;
        top_d.err = |illegal_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign cmd_err    = top_q.err;
    assign qry_status = qst;

endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
    parameter int NUM_BANKS = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [BA_W-1:0]      ba,
    input logic                 a10,
    input logic [BA_W-1:0]      qry_bank,
    input logic [1:0]           qry_status,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 cmd_err
);

    logic is_act, is_rd, is_pre;
    assign is_act = !cs_n && !ras_n && cas_n && we_n;
    assign is_rd  = !cs_n && ras_n && !cas_n && we_n;
    assign is_pre = !cs_n && !ras_n && cas_n && !we_n;

    assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && !bank_open[ba]) |=> bank_open[$past(ba)]);

    assert_act_open_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && bank_open[ba]) |=> cmd_err);

    assert_rd_idle_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && !bank_open[ba]) |=> cmd_err);

    assert_pre_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && a10) |=> (bank_open == '0));

    assert_deselect_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !cmd_err);

    assert_idle_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_open[qry_bank] |-> (qry_status == 2'd0));

    assert_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        qry_status != 2'd3);

endmodule

bind bank_row_tracker brt_checker #(
    .NUM_BANKS (NUM_BANKS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .a10        (addr[10]),
    .qry_bank   (qry_bank),
    .qry_status (qry_status),
    .bank_open  (bank_open),
    .cmd_err    (cmd_err)
);

// File: tb/bank_row_tracker_tb.sv
module bank_row_tracker_tb_top;

    localparam int CLK_P = 10;
    localparam int BL    = 4;

    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_DES = 4'b1010;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_REF = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [1:0]  qry_bank = '0;
    logic [12:0] qry_row = '0;
    logic [1:0]  qry_status;
    logic [3:0]  bank_open;
    logic        cmd_err;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string       tag;
        logic [3:0]  eo;
        logic        ee;
        logic [1:0]  qb;
        logic [12:0] qr;
        logic [1:0]  es;
    } item_t;

    item_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    bank_row_tracker #(
        .NUM_BANKS (4),
        .ROW_W     (13),
        .BURST_LEN (BL)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .ba         (ba),
        .addr       (addr),
        .qry_bank   (qry_bank),
        .qry_row    (qry_row),
        .qry_status (qry_status),
        .bank_open  (bank_open),
        .cmd_err    (cmd_err)
    );

    // driver: one command per cycle, expected result pushed after the edge
    task automatic step(input logic [3:0] pins, input logic [1:0] b, input logic [12:0] a,
                        input logic [1:0] qb, input logic [12:0] qr,
                        input logic [3:0] eo, input logic ee, input logic [1:0] es,
                        input string tag);
        item_t it;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = pins;
        ba   = b;
        addr = a;
        @(posedge clk);
        #1;
        it.tag = tag; it.eo = eo; it.ee = ee; it.qb = qb; it.qr = qr; it.es = es;
        sb_q.push_back(it);
    endtask

    // monitor: pops expectations, sets the query, compares the outputs
    initial begin
        item_t it;
        forever begin
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            qry_bank = it.qb;
            qry_row  = it.qr;
            #1;
            checks++;
            if (bank_open !== it.eo) begin
                fails++;
                $display("FAIL %s bank_open act=%b exp=%b", it.tag, bank_open, it.eo);
            end
            checks++;
            if (cmd_err !== it.ee) begin
                fails++;
                $display("FAIL %s cmd_err act=%b exp=%b", it.tag, cmd_err, it.ee);
            end
            checks++;
            if (qry_status !== it.es) begin
                fails++;
                $display("FAIL %s qry_status act=%0d exp=%0d", it.tag, qry_status, it.es);
            end
        end
    end

    initial begin
        #(CLK_P * 5000);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = P_NOP;

        step(P_NOP, 0, 13'h000, 0, 13'h000, 4'b0000, 0, 0, "R1 reset");
        step(P_ACT, 0, 13'h123, 0, 13'h123, 4'b0001, 0, 1, "R2 open b0");
        step(P_NOP, 0, 13'h000, 0, 13'h124, 4'b0001, 0, 2, "R9 conflict");
        step(P_NOP, 0, 13'h000, 1, 13'h123, 4'b0001, 0, 0, "R8 nop/R9 idle");
        step(P_ACT, 0, 13'h055, 0, 13'h055, 4'b0001, 1, 2, "R3 act open bank");
        step(P_NOP, 0, 13'h000, 0, 13'h123, 4'b0001, 0, 1, "R3 pulse ends row kept");
        step(P_RD,  1, 13'h000, 1, 13'h000, 4'b0001, 1, 0, "R4 read idle");
        step(P_RD,  0, 13'h004, 0, 13'h123, 4'b0001, 0, 1, "R4 read no close");
        step(P_ACT, 2, 13'h1AA, 2, 13'h1AA, 4'b0101, 0, 1, "R2 open b2");
        step(P_RD,  2, 13'h400, 2, 13'h1AA, 4'b0101, 0, 1, "R5 autoclose start");
        step(P_DES, 0, 13'h400, 2, 13'h1AA, 4'b0101, 0, 1, "R7 deselect ignored");
        step(P_NOP, 0, 13'h000, 2, 13'h1AA, 4'b0001, 0, 0, "R5 closes after BL/2");
        step(P_PRE, 0, 13'h000, 0, 13'h123, 4'b0000, 0, 0, "R6 close one");
        step(P_ACT, 0, 13'h005, 0, 13'h005, 4'b0001, 0, 1, "R2 b0");
        step(P_ACT, 1, 13'h006, 1, 13'h006, 4'b0011, 0, 1, "R2 b1");
        step(P_ACT, 3, 13'h007, 3, 13'h007, 4'b1011, 0, 1, "R2 b3");
        step(P_PRE, 1, 13'h000, 3, 13'h007, 4'b1001, 0, 1, "R6 single bank");
        step(P_RD,  3, 13'h400, 3, 13'h007, 4'b1001, 0, 1, "R5 b3 start");
        step(P_NOP, 0, 13'h000, 3, 13'h007, 4'b1001, 0, 1, "R5 b3 pending");
        step(P_ACT, 1, 13'h0AB, 1, 13'h0AB, 4'b0011, 0, 1, "R5 expiry with act other");
        step(P_RD,  0, 13'h400, 0, 13'h005, 4'b0011, 0, 1, "R5 b0 start");
        step(P_NOP, 0, 13'h000, 0, 13'h005, 4'b0011, 0, 1, "R5 b0 pending");
        step(P_ACT, 0, 13'h077, 0, 13'h077, 4'b0010, 1, 0, "R3 act on expiry edge");
        step(P_RD,  1, 13'h400, 1, 13'h0AB, 4'b0010, 0, 1, "R5 b1 start");
        step(P_PRE, 1, 13'h000, 1, 13'h0AB, 4'b0000, 0, 0, "R6 cancel pending");
        step(P_ACT, 1, 13'h00C, 1, 13'h00C, 4'b0010, 0, 1, "R6 no stale close");
        step(P_NOP, 0, 13'h000, 1, 13'h00C, 4'b0010, 0, 1, "R6 still open");
        step(P_WR,  1, 13'h400, 1, 13'h00C, 4'b0010, 0, 1, "R10 write ignored");
        step(P_REF, 1, 13'h000, 1, 13'h00C, 4'b0010, 0, 1, "R10 refresh ignored");
        step(P_ACT, 2, 13'h003, 2, 13'h003, 4'b0110, 0, 1, "R2 b2 again");
        step(P_NOP, 0, 13'h000, 2, 13'h004, 4'b0110, 0, 2, "R9 conflict b2");
        step(P_PRE, 0, 13'h400, 2, 13'h003, 4'b0000, 0, 0, "R6 close all");
        step(P_NOP, 0, 13'h000, 1, 13'h00C, 4'b0000, 0, 0, "R8 quiet end");

        wait (sb_q.size() == 0);
        #(CLK_P);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule